// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Channel

This block is the receive side of a DMA channel. Software puts three-word descriptors in memory and hands the address of the first one to the channel. The channel then moves bytes from a peripheral stream into the buffers those descriptors name. It fetches each descriptor and validates it. It packs incoming bytes little-endian into 32-bit words and writes them out over a single-beat memory port. When a buffer is finished, it returns the descriptor to software by rewriting word 0 with the received length and the frame-end flag.

Descriptor word 0 has four fields. Bit 31 is the owner (1 = DMA, 0 = CPU). Bit 30 is the frame-end flag. Bits [23:12] are the received length and bits [11:0] are the buffer size. Word 1 is the buffer byte address. Word 2 is the next descriptor's address, and 0 ends the chain. One-cycle event pulses report these conditions:

- a buffer completed
- a frame ended cleanly
- a frame ended with a data error
- a bad descriptor was fetched
- the chain ran out in the middle of a frame

The channel also exposes the current descriptor address, plus the descriptor addresses that held the last clean frame end and the last errored frame end. Command inputs can stop the channel, reset it, or resume a parked chain after software links a further descriptor behind the last one.

Top module: `rxlink_dma`

## Requirements
- R1: After rst_n or a chan_rst_i pulse, park_o is 1, in_ready_o is 0 and mem_req_o is 0. A frame started after chan_rst_i places its first byte at lane 0 of its buffer.
- R2: A start_i pulse while parked makes the channel read words 0, 1 and 2 of the descriptor at first_addr_i. cur_dscr_o then equals first_addr_i and park_o is 0 while the channel works.
- R3: A fetched descriptor is bad in any of these cases: owner checking is on and bit 31 of word 0 is 0; the size field is 0; the low two bits of word 1 are nonzero; the low two bits of word 2 are nonzero. A bad descriptor gives one ev_dscr_err_o pulse and parks the channel, and no buffer byte is written.
- R4: Byte k of a buffer is written to buffer address + k, in lane k mod 4 of a 32-bit word. A word is written when its lane 3 fills, when the buffer fills, or when the frame ends. Byte enables are contiguous from lane 0, and bytes past the frame end keep their old contents.
- R5: When a buffer completes, word 0 of its descriptor is rewritten as bit 31 = 0, bit 30 = frame end, [23:12] = bytes received, [11:0] = size, other bits 0. ev_done_o then pulses once.
- R6: A frame whose bytes carried no in_err_i gives ev_suc_eof_o at its end, and suc_eof_addr_o takes that descriptor's address.
- R7: If in_err_i accompanied any byte of a frame, the frame end gives ev_err_eof_o instead, and err_eof_addr_o takes that descriptor's address. The two frame-end events never pulse together.
- R8: If a buffer fills before the frame ends and word 2 is 0, ev_dscr_empty_o pulses and the channel parks.
- R9: When auto_ret_i is 1 and a frame ends with an error, the descriptor is not rewritten and ev_done_o does not pulse. ev_err_eof_o still pulses, and the same descriptor is fetched again for the next frame.
- R10: A stop_i pulse parks the channel at the next clock edge.
- R11: A restart_i pulse while parked rereads word 2 of the current descriptor. If that word is nonzero, reception continues in the descriptor it names and the frame carries on.
- R12: When a buffer completes and word 2 is nonzero, the named descriptor is fetched next. When word 2 is 0 and the frame has ended, the channel parks without ev_dscr_empty_o.
- R13: With chk_owner_i at 0, a descriptor whose owner bit is 0 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst_i | input | 1 | Synchronous channel reset of FSM and packing state |
| start_i | input | 1 | Begin at first_addr_i |
| stop_i | input | 1 | Halt descriptor processing |
| restart_i | input | 1 | Resume from word 2 of the current descriptor |
| auto_ret_i | input | 1 | Refetch current descriptor after an errored frame |
| chk_owner_i | input | 1 | Enable owner-bit check |
| first_addr_i | input | 20 | First descriptor byte address |
| park_o | output | 1 | 1 while idle |
| cur_dscr_o | output | 20 | Current descriptor address |
| suc_eof_addr_o | output | 20 | Descriptor of last clean frame end |
| err_eof_addr_o | output | 20 | Descriptor of last errored frame end |
| ev_done_o | output | 1 | Buffer completed |
| ev_suc_eof_o | output | 1 | Clean frame end |
| ev_err_eof_o | output | 1 | Errored frame end |
| ev_dscr_err_o | output | 1 | Bad descriptor |
| ev_dscr_empty_o | output | 1 | Chain exhausted mid-frame |
| in_valid_i | input | 1 | Byte valid |
| in_data_i | input | 8 | Byte |
| in_eof_i | input | 1 | Byte is last of frame |
| in_err_i | input | 1 | Byte carries a data error |
| in_ready_o | output | 1 | Byte accepted when valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | 20 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |

## Verification
The bench builds the block with the default widths: a 20-bit address and 12-bit length and size fields. Descriptors use buffer sizes of 2 to 32 bytes, so lane-3 flushes, buffer-full handoff to a following descriptor, exact fills at frame end and chain exhaustion each happen within a handful of bytes. A zero-latency memory model acknowledges each request in the cycle it is made, so every descriptor fetch and writeback lands on a predictable cycle.

// File: rtl/rxlink_pkg.sv
package rxlink_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int OWN_BIT    = 31;
    localparam int EOF_BIT    = 30;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_RD0    = 4'd1,
        ST_RD1    = 4'd2,
        ST_RD2    = 4'd3,
        ST_CHECK  = 4'd4,
        ST_RECV   = 4'd5,
        ST_WRDATA = 4'd6,
        ST_WBACK  = 4'd7,
        ST_RELINK = 4'd8
    } rx_state_e;
endpackage

// File: rtl/rxlink_dscr_chk.sv
module rxlink_dscr_chk
    import rxlink_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int FLD_W  = 12
) (
    input  logic              chk_owner_i,
    input  logic [WORD_W-1:0] w0_i,
    input  logic [ADDR_W-1:0] bufa_i,
    input  logic [ADDR_W-1:0] nxt_i,
    output logic              bad_o
);
    logic owner_bad, size_bad, align_bad;

    always_comb begin
        owner_bad = chk_owner_i & ~w0_i[OWN_BIT];
        size_bad  = (w0_i[FLD_W-1:0] == '0);
        align_bad = (bufa_i[1:0] != 2'b00) | (nxt_i[1:0] != 2'b00);
        bad_o     = owner_bad | size_bad | align_bad;
    end
endmodule

// File: rtl/rxlink_packer.sv
module rxlink_packer
    import rxlink_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  push_i,
    input  logic [LANE_W-1:0]     lane_i,
    input  logic [7:0]            byte_i,
    output logic [WORD_W-1:0]     word_o,
    output logic [WORD_BYTES-1:0] be_o
);
    typedef struct packed {
        logic [WORD_W-1:0]     word;
        logic [WORD_BYTES-1:0] be;
    } pk_s;

    pk_s pk_d, pk_q;
    logic [WORD_BYTES-1:0] lane_hit;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_hit[g] = push_i && (lane_i == LANE_W'(g));
    end

    always_comb begin
        pk_d = pk_q;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (lane_hit[b]) pk_d.word[8*b +: 8] = byte_i;
        end
        if (push_i) begin
            pk_d.be = (lane_i == '0) ? lane_hit : (pk_q.be | lane_hit);
        end
        if (clr_i) pk_d.be = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o = pk_q.word;
    assign be_o   = pk_q.be;

    assert_be_from_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && lane_i == '0) |=> (be_o == WORD_BYTES'(1)));
endmodule

// File: rtl/rxlink_fsm.sv
module rxlink_fsm
    import rxlink_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int FLD_W  = 12,
    parameter int LANE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chan_rst_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  restart_i,
    input  logic                  auto_ret_i,
    input  logic [ADDR_W-1:0]     first_addr_i,
    input  logic                  dscr_bad_i,
    input  logic                  in_valid_i,
    input  logic                  in_eof_i,
    input  logic                  in_err_i,
    output logic                  in_ready_o,
    output logic                  pk_push_o,
    output logic                  pk_clr_o,
    output logic [LANE_W-1:0]     pk_lane_o,
    input  logic [WORD_W-1:0]     pk_word_i,
    input  logic [WORD_BYTES-1:0] pk_be_i,
    output logic                  mem_req_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [WORD_W-1:0]     mem_wdata_o,
    output logic [WORD_BYTES-1:0] mem_be_o,
    input  logic                  mem_ack_i,
    input  logic [WORD_W-1:0]     mem_rdata_i,
    output logic [WORD_W-1:0]     w0_o,
    output logic [ADDR_W-1:0]     bufa_o,
    output logic [ADDR_W-1:0]     nxt_o,
    output logic                  park_o,
    output logic [ADDR_W-1:0]     cur_dscr_o,
    output logic [ADDR_W-1:0]     suc_addr_o,
    output logic [ADDR_W-1:0]     err_addr_o,
    output logic                  ev_done_o,
    output logic                  ev_suc_o,
    output logic                  ev_err_o,
    output logic                  ev_derr_o,
    output logic                  ev_empty_o
);
    localparam int PAD_W = WORD_W - 2 - 2 * FLD_W;
    localparam logic [ADDR_W-1:0] OFS_W1 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_W2 = ADDR_W'(8);
    localparam logic [FLD_W-1:0]  CNT_ONE = FLD_W'(1);

    typedef struct packed {
        rx_state_e         st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] bufa;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] suc_addr;
        logic [ADDR_W-1:0] err_addr;
        logic [WORD_W-1:0] w0;
        logic [FLD_W-1:0]  cnt;
        logic              eof_seen;
        logic              err_seen;
        logic              linked;
        logic              ev_done;
        logic              ev_suc;
        logic              ev_err;
        logic              ev_derr;
        logic              ev_empty;
    } fsm_s;

    fsm_s fsm_d, fsm_q;
    logic halt, accept, buf_full_next;
    logic [FLD_W-1:0] size_q;

    assign size_q = fsm_q.w0[FLD_W-1:0];

    always_comb begin
        fsm_d          = fsm_q;
        fsm_d.ev_done  = 1'b0;
        fsm_d.ev_suc   = 1'b0;
        fsm_d.ev_err   = 1'b0;
        fsm_d.ev_derr  = 1'b0;
        fsm_d.ev_empty = 1'b0;
        halt           = stop_i | chan_rst_i;
        accept         = (fsm_q.st == ST_RECV) && in_valid_i && !halt;
        buf_full_next  = ((fsm_q.cnt + CNT_ONE) == size_q);
        in_ready_o     = 1'b0;
        mem_req_o      = 1'b0;
        mem_we_o       = 1'b0;
        mem_addr_o     = fsm_q.cur;
        mem_wdata_o    = '0;
        mem_be_o       = '0;
        pk_push_o      = 1'b0;
        pk_lane_o      = fsm_q.cnt[LANE_W-1:0];
        pk_clr_o       = chan_rst_i | (fsm_q.st == ST_CHECK);

        case (fsm_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d.cur      = first_addr_i;
                    fsm_d.eof_seen = 1'b0;
                    fsm_d.err_seen = 1'b0;
                    fsm_d.st       = ST_RD0;
                end else if (restart_i && fsm_q.linked) begin
                    fsm_d.st = ST_RELINK;
                end
            end
            ST_RD0: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    fsm_d.w0 = mem_rdata_i;
                    fsm_d.st = ST_RD1;
                end
            end
            ST_RD1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = fsm_q.cur + OFS_W1;
                if (mem_ack_i) begin
                    fsm_d.bufa = mem_rdata_i[ADDR_W-1:0];
                    fsm_d.st   = ST_RD2;
                end
            end
            ST_RD2: begin
                mem_req_o  = 1'b1;
                mem_addr_o = fsm_q.cur + OFS_W2;
                if (mem_ack_i) begin
                    fsm_d.nxt = mem_rdata_i[ADDR_W-1:0];
                    fsm_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                fsm_d.cnt = '0;
                if (dscr_bad_i) begin
                    fsm_d.ev_derr = 1'b1;
                    fsm_d.linked  = 1'b0;
                    fsm_d.st      = ST_IDLE;
                end else begin
                    fsm_d.linked = 1'b1;
                    fsm_d.st     = ST_RECV;
                end
            end
            ST_RECV: begin
                in_ready_o = 1'b1;
                if (accept) begin
                    pk_push_o     = 1'b1;
                    fsm_d.wr_addr = fsm_q.bufa +
                        ADDR_W'({fsm_q.cnt[FLD_W-1:LANE_W], {LANE_W{1'b0}}});
                    fsm_d.cnt     = fsm_q.cnt + CNT_ONE;
                    if (in_eof_i) fsm_d.eof_seen = 1'b1;
                    if (in_err_i) fsm_d.err_seen = 1'b1;
                    if ((&fsm_q.cnt[LANE_W-1:0]) || buf_full_next || in_eof_i)
                        fsm_d.st = ST_WRDATA;
                end
            end
            ST_WRDATA: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = fsm_q.wr_addr;
                mem_wdata_o = pk_word_i;
                mem_be_o    = pk_be_i;
                if (mem_ack_i) begin
                    if (fsm_q.eof_seen && fsm_q.err_seen && auto_ret_i) begin
                        fsm_d.ev_err   = 1'b1;
                        fsm_d.err_addr = fsm_q.cur;
                        fsm_d.eof_seen = 1'b0;
                        fsm_d.err_seen = 1'b0;
                        fsm_d.st       = ST_RD0;
                    end else if (fsm_q.eof_seen || (fsm_q.cnt == size_q)) begin
                        fsm_d.st = ST_WBACK;
                    end else begin
                        fsm_d.st = ST_RECV;
                    end
                end
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_be_o    = '1;
                mem_wdata_o = {1'b0, fsm_q.eof_seen, {PAD_W{1'b0}},
                               fsm_q.cnt, size_q};
                if (mem_ack_i) begin
                    fsm_d.ev_done = 1'b1;
                    if (fsm_q.eof_seen) begin
                        if (fsm_q.err_seen) begin
                            fsm_d.ev_err   = 1'b1;
                            fsm_d.err_addr = fsm_q.cur;
                        end else begin
                            fsm_d.ev_suc   = 1'b1;
                            fsm_d.suc_addr = fsm_q.cur;
                        end
                        fsm_d.eof_seen = 1'b0;
                        fsm_d.err_seen = 1'b0;
                    end
                    if (fsm_q.nxt != '0) begin
                        fsm_d.cur = fsm_q.nxt;
                        fsm_d.st  = ST_RD0;
                    end else begin
                        fsm_d.ev_empty = !fsm_q.eof_seen;
                        fsm_d.st       = ST_IDLE;
                    end
                end
            end
            ST_RELINK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = fsm_q.cur + OFS_W2;
                if (mem_ack_i) begin
                    if (mem_rdata_i[ADDR_W-1:0] != '0) begin
                        fsm_d.cur = mem_rdata_i[ADDR_W-1:0];
                        fsm_d.st  = ST_RD0;
                    end else begin
                        fsm_d.st = ST_IDLE;
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase

        if (halt) begin
            mem_req_o      = 1'b0;
            in_ready_o     = 1'b0;
            pk_push_o      = 1'b0;
            fsm_d.st       = ST_IDLE;
            fsm_d.ev_done  = 1'b0;
            fsm_d.ev_suc   = 1'b0;
            fsm_d.ev_err   = 1'b0;
            fsm_d.ev_derr  = 1'b0;
            fsm_d.ev_empty = 1'b0;
        end
        if (chan_rst_i) begin
            fsm_d.cnt      = '0;
            fsm_d.eof_seen = 1'b0;
            fsm_d.err_seen = 1'b0;
            fsm_d.linked   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign w0_o       = fsm_q.w0;
    assign bufa_o     = fsm_q.bufa;
    assign nxt_o      = fsm_q.nxt;
    assign park_o     = (fsm_q.st == ST_IDLE);
    assign cur_dscr_o = fsm_q.cur;
    assign suc_addr_o = fsm_q.suc_addr;
    assign err_addr_o = fsm_q.err_addr;
    assign ev_done_o  = fsm_q.ev_done;
    assign ev_suc_o   = fsm_q.ev_suc;
    assign ev_err_o   = fsm_q.ev_err;
    assign ev_derr_o  = fsm_q.ev_derr;
    assign ev_empty_o = fsm_q.ev_empty;

    assert_chan_rst_parks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst_i |=> (park_o && !in_ready_o && !mem_req_o));
    assert_ready_no_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !mem_req_o);
    assert_be_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |->
        (mem_be_o == 4'b0001 || mem_be_o == 4'b0011 ||
         mem_be_o == 4'b0111 || mem_be_o == 4'b1111));
    assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done_o |-> $past(mem_req_o && mem_we_o && mem_be_o == 4'b1111));
    assert_eof_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_suc_o && ev_err_o));
    assert_dscr_err_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_derr_o |-> (park_o && !ev_done_o));
    assert_empty_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty_o |-> (park_o && ev_done_o));
    assert_stop_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> park_o);
endmodule

// File: rtl/rxlink_dma.sv
module rxlink_dma
    import rxlink_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int FLD_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chan_rst_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  restart_i,
    input  logic                  auto_ret_i,
    input  logic                  chk_owner_i,
    input  logic [ADDR_W-1:0]     first_addr_i,
    output logic                  park_o,
    output logic [ADDR_W-1:0]     cur_dscr_o,
    output logic [ADDR_W-1:0]     suc_eof_addr_o,
    output logic [ADDR_W-1:0]     err_eof_addr_o,
    output logic                  ev_done_o,
    output logic                  ev_suc_eof_o,
    output logic                  ev_err_eof_o,
    output logic                  ev_dscr_err_o,
    output logic                  ev_dscr_empty_o,
    input  logic                  in_valid_i,
    input  logic [7:0]            in_data_i,
    input  logic                  in_eof_i,
    input  logic                  in_err_i,
    output logic                  in_ready_o,
    output logic                  mem_req_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [WORD_W-1:0]     mem_wdata_o,
    output logic [WORD_BYTES-1:0] mem_be_o,
    input  logic                  mem_ack_i,
    input  logic [WORD_W-1:0]     mem_rdata_i
);
    localparam int LANE_W = $clog2(WORD_BYTES);

    logic                  dscr_bad;
    logic                  pk_push, pk_clr;
    logic [LANE_W-1:0]     pk_lane;
    logic [WORD_W-1:0]     pk_word;
    logic [WORD_BYTES-1:0] pk_be;
    logic [WORD_W-1:0]     w0;
    logic [ADDR_W-1:0]     bufa, nxt;

    rxlink_fsm #(.ADDR_W(ADDR_W), .FLD_W(FLD_W), .LANE_W(LANE_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_rst_i  (chan_rst_i),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .restart_i   (restart_i),
        .auto_ret_i  (auto_ret_i),
        .first_addr_i(first_addr_i),
        .dscr_bad_i  (dscr_bad),
        .in_valid_i  (in_valid_i),
        .in_eof_i    (in_eof_i),
        .in_err_i    (in_err_i),
        .in_ready_o  (in_ready_o),
        .pk_push_o   (pk_push),
        .pk_clr_o    (pk_clr),
        .pk_lane_o   (pk_lane),
        .pk_word_i   (pk_word),
        .pk_be_i     (pk_be),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_be_o    (mem_be_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .w0_o        (w0),
        .bufa_o      (bufa),
        .nxt_o       (nxt),
        .park_o      (park_o),
        .cur_dscr_o  (cur_dscr_o),
        .suc_addr_o  (suc_eof_addr_o),
        .err_addr_o  (err_eof_addr_o),
        .ev_done_o   (ev_done_o),
        .ev_suc_o    (ev_suc_eof_o),
        .ev_err_o    (ev_err_eof_o),
        .ev_derr_o   (ev_dscr_err_o),
        .ev_empty_o  (ev_dscr_empty_o)
    );

    rxlink_packer #(.LANE_W(LANE_W)) packer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pk_clr),
        .push_i(pk_push),
        .lane_i(pk_lane),
        .byte_i(in_data_i),
        .word_o(pk_word),
        .be_o  (pk_be)
    );

    rxlink_dscr_chk #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) chk_i (
        .chk_owner_i(chk_owner_i),
        .w0_i       (w0),
        .bufa_i     (bufa),
        .nxt_i      (nxt),
        .bad_o      (dscr_bad)
    );
endmodule

// File: tb/rxlink_dma_tb_top.sv
module rxlink_dma_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_rst = 0, start = 0, stop = 0, restart = 0, auto_ret = 0, chk_owner = 1;
    logic [19:0] first_addr = '0;
    logic park, ev_done, ev_suc, ev_err, ev_derr, ev_empty;
    logic [19:0] cur_dscr, suc_addr, err_addr;
    logic in_valid = 0, in_eof = 0, in_err = 0, in_ready;
    logic [7:0] in_data = '0;
    logic mem_req, mem_we, mem_ack;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [31:0] mem [0:255];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int c_done = 0, c_suc = 0, c_err = 0, c_derr = 0, c_empty = 0;

    always #2.5 clk = ~clk;

    rxlink_dma dut_i (
        .clk(clk), .rst_n(rst_n), .chan_rst_i(chan_rst), .start_i(start), .stop_i(stop),
        .restart_i(restart), .auto_ret_i(auto_ret), .chk_owner_i(chk_owner),
        .first_addr_i(first_addr), .park_o(park), .cur_dscr_o(cur_dscr),
        .suc_eof_addr_o(suc_addr), .err_eof_addr_o(err_addr), .ev_done_o(ev_done),
        .ev_suc_eof_o(ev_suc), .ev_err_eof_o(ev_err), .ev_dscr_err_o(ev_derr),
        .ev_dscr_empty_o(ev_empty), .in_valid_i(in_valid), .in_data_i(in_data),
        .in_eof_i(in_eof), .in_err_i(in_err), .in_ready_o(in_ready), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
        .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_done)  c_done++;
            if (ev_suc)   c_suc++;
            if (ev_err)   c_err++;
            if (ev_derr)  c_derr++;
            if (ev_empty) c_empty++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, 100000);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    function automatic logic [31:0] wb(input logic eof, input int len, input int size);
        return {1'b0, eof, 6'b0, 12'(len), 12'(size)};
    endfunction

    task automatic set_dscr(input int a, input logic own, input int size, input int bufa, input int nxt);
        mem[a >> 2]       = {own, 1'b0, 18'b0, 12'(size)};
        mem[(a >> 2) + 1] = 32'(bufa);
        mem[(a >> 2) + 2] = 32'(nxt);
    endtask

    task automatic fill_bufs();
        for (int w = 128; w < 256; w++) mem[w] = 32'hEEEE_EEEE;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go(input int a);
        @(negedge clk); first_addr = 20'(a); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic send(input int first, input int n, input logic eof_end,
                        input logic err_end, input logic [7:0] base);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1; in_data = base + 8'(first + k);
            in_eof = eof_end && (k == n - 1);
            in_err = err_end && (k == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 0; in_eof = 0; in_err = 0;
    endtask

    task automatic chk_data(input string req, input int bufa, input int first,
                            input int n, input logic [7:0] base);
        for (int k = 0; k < n; k++) chk(req, 32'(mbyte(bufa + k)), 32'(base + 8'(first + k)));
        if ((n % 4) != 0) chk(req, 32'(mbyte(bufa + n)), 32'h0000_00EE);
    endtask

    // {length, size, error, owner check, owner, pad}
    localparam logic [19:0] VEC [6] = '{
        {8'd1,  8'd16, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd4,  8'd16, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd7,  8'd8,  1'b1, 1'b1, 1'b1, 1'b0},
        {8'd8,  8'd8,  1'b0, 1'b1, 1'b1, 1'b0},
        {8'd13, 8'd32, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd2,  8'd2,  1'b1, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        for (int w = 0; w < 256; w++) mem[w] = '0;
        tick(3);
        // R1: reset state
        chk("R1 park", 32'(park), 1);
        chk("R1 ready", 32'(in_ready), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        rst_n = 1;
        tick(2);

        // Table of single-descriptor frames (R4 R5 R6 R7 R12 R13)
        for (int v = 0; v < 6; v++) begin
            automatic int len  = int'(VEC[v][19:12]);
            automatic int size = int'(VEC[v][11:4]);
            automatic logic er = VEC[v][3];
            automatic int d0 = c_done, s0 = c_suc, e0 = c_err, m0 = c_empty;
            automatic logic [7:0] base = 8'(16 * v + 1);
            fill_bufs();
            set_dscr(32'h100, VEC[v][1], size, 32'h200, 0);
            chk_owner = VEC[v][2];
            go(32'h100);
            send(0, len, 1'b1, er, base);
            tick(8);
            chk("R5 done count", 32'(c_done - d0), 1);
            chk("R5 writeback", mem[32'h100 >> 2], wb(1'b1, len, size));
            chk(er ? "R7 err count" : "R6 suc count", 32'(er ? c_err - e0 : c_suc - s0), 1);
            chk("R7 no other eof", 32'(er ? c_suc - s0 : c_err - e0), 0);
            if (er) chk("R7 err addr", 32'(err_addr), 32'h100);
            else    chk("R6 suc addr", 32'(suc_addr), 32'h100);
            chk("R12 park no empty", {31'b0, park} | 32'(c_empty - m0) << 1, 1);
            chk_data(VEC[v][2] ? "R4 data" : "R13 data owner0", 32'h200, 0, len, base);
        end
        chk_owner = 1;

        // R3: bad descriptors
        for (int c = 0; c < 4; c++) begin
            automatic int x0 = c_derr, d0 = c_done;
            fill_bufs();
            case (c)
                0: set_dscr(32'h100, 1'b0, 8, 32'h200, 0);
                1: set_dscr(32'h100, 1'b1, 0, 32'h200, 0);
                2: set_dscr(32'h100, 1'b1, 8, 32'h201, 0);
                default: set_dscr(32'h100, 1'b1, 8, 32'h200, 32'h112);
            endcase
            go(32'h100);
            tick(8);
            chk("R3 dscr err", 32'(c_derr - x0), 1);
            chk("R3 parked", 32'(park), 1);
            chk("R3 no done", 32'(c_done - d0), 0);
            chk("R3 buffer untouched", mem[32'h200 >> 2], 32'hEEEE_EEEE);
        end

        // R12 R4 R5: two-descriptor chain
        begin
            automatic int d0 = c_done, s0 = c_suc;
            fill_bufs();
            set_dscr(32'h100, 1'b1, 6, 32'h200, 32'h110);
            set_dscr(32'h110, 1'b1, 16, 32'h280, 0);
            go(32'h100);
            send(0, 10, 1'b1, 1'b0, 8'h40);
            tick(8);
            chk("R12 chain done", 32'(c_done - d0), 2);
            chk("R12 chain suc", 32'(c_suc - s0), 1);
            chk("R6 chain suc addr", 32'(suc_addr), 32'h110);
            chk("R5 first wb", mem[32'h100 >> 2], wb(1'b0, 6, 6));
            chk("R5 second wb", mem[32'h110 >> 2], wb(1'b1, 4, 16));
            chk_data("R4 chain buf0", 32'h200, 0, 6, 8'h40);
            chk_data("R4 chain buf1", 32'h280, 6, 4, 8'h40);
        end

        // R8 R11: chain runs dry, then restart after linking
        begin
            automatic int m0 = c_empty, s0 = c_suc;
            fill_bufs();
            set_dscr(32'h100, 1'b1, 4, 32'h200, 0);
            go(32'h100);
            send(0, 4, 1'b0, 1'b0, 8'h60);
            tick(6);
            chk("R8 empty event", 32'(c_empty - m0), 1);
            chk("R8 parked", 32'(park), 1);
            chk("R8 cur kept", 32'(cur_dscr), 32'h100);
            set_dscr(32'h110, 1'b1, 16, 32'h280, 0);
            mem[(32'h100 >> 2) + 2] = 32'h110;
            @(negedge clk); restart = 1;
            @(negedge clk); restart = 0;
            send(4, 2, 1'b1, 1'b0, 8'h60);
            tick(8);
            chk("R11 suc after restart", 32'(c_suc - s0), 1);
            chk("R11 suc addr", 32'(suc_addr), 32'h110);
            chk("R11 wb", mem[32'h110 >> 2], wb(1'b1, 2, 16));
            chk_data("R11 data", 32'h280, 4, 2, 8'h60);
        end

        // R9 R10: auto-return on error, then stop
        begin
            automatic int d0 = c_done, e0 = c_err, s0 = c_suc;
            fill_bufs();
            auto_ret = 1;
            set_dscr(32'h100, 1'b1, 16, 32'h200, 32'h110);
            set_dscr(32'h110, 1'b1, 16, 32'h280, 0);
            go(32'h100);
            send(0, 3, 1'b1, 1'b1, 8'h80);
            tick(8);
            chk("R9 err event", 32'(c_err - e0), 1);
            chk("R9 err addr", 32'(err_addr), 32'h100);
            chk("R9 no done", 32'(c_done - d0), 0);
            chk("R9 dscr not rewritten", mem[32'h100 >> 2], {1'b1, 19'b0, 12'd16});
            chk("R9 same dscr", 32'(cur_dscr), 32'h100);
            chk("R9 working", 32'(park), 0);
            send(0, 2, 1'b1, 1'b0, 8'h90);
            tick(8);
            chk("R9 suc after return", 32'(c_suc - s0), 1);
            chk("R9 wb after return", mem[32'h100 >> 2], wb(1'b1, 2, 16));
            chk("R12 moved to next", 32'(cur_dscr), 32'h110);
            auto_ret = 0;
            @(negedge clk); stop = 1;
            @(negedge clk); stop = 0;
            chk("R10 stop parks", 32'(park), 1);
            chk("R10 no ready", 32'(in_ready), 0);
        end

        // R1 R2: channel reset mid-frame, restart from lane 0
        begin
            fill_bufs();
            set_dscr(32'h100, 1'b1, 16, 32'h200, 0);
            go(32'h100);
            tick(6);
            chk("R2 cur addr", 32'(cur_dscr), 32'h100);
            chk("R2 working", 32'(park), 0);
            send(0, 2, 1'b0, 1'b0, 8'hA0);
            @(negedge clk); chan_rst = 1;
            @(negedge clk); chan_rst = 0;
            chk("R1 chan_rst park", 32'(park), 1);
            chk("R1 chan_rst ready", 32'(in_ready), 0);
            go(32'h100);
            send(0, 1, 1'b1, 1'b0, 8'hC0);
            tick(8);
            chk("R1 lane0 after reset", 32'(mbyte(32'h200)), 32'h0000_00C0);
            chk("R1 wb after reset", mem[32'h100 >> 2], wb(1'b1, 1, 16));
        end

        summary();
    end
endmodule